// File: doc/BRIEF.md
# Channel Command Stream Decoder

The decoder takes a stream of 32-bit command words on a valid/ready input and turns them into register-write transactions. Each transaction carries a class ID, a 12-bit method offset and a 32-bit data word. A header word picks a submission mode and loads state: a current class, a base offset, a word count with an increment flag, or a sparse bit mask. That state decides where the payload words that follow are written.

Pending mask state is served before pending count state, and a word is read as a new header only when both are empty. Mask-driven writes go to the base offset plus the position of the lowest remaining mask bit, so a sparse set of registers is written in ascending order from one header. Every write is also stored in a small register file that belongs to its class. One file serves the decoder class and one serves an auxiliary class. A combinational read port exposes both files.

Top module: `chan_cmd_decoder`

## Requirements
- R1: After reset no write is pending, `in_ready` is high, and the current class, offset, count, mask and increment flag are zero. A payload-carrying header issued straight after reset therefore writes with class 0.
- R2: A header word holds the mode code in bits 31:28, the method offset in bits 27:16 and a 16-bit value in bits 15:0. Mode code 0 (set-class) loads the class from value bits 15:6, the base offset from the header, and a 6-bit mask from value bits 5:0. The words that follow are then written as for R5.
- R3: Mode code 1 (incrementing burst) loads a 16-bit count from the value field. Each following word is written to the current offset and decrements the count, and the offset then advances by one.
- R4: Mode code 2 (non-incrementing burst) behaves as R3, except that every payload word is written to the same offset.
- R5: Mode code 3 (mask) loads a 16-bit mask. Each following word is written to base offset plus the index of the lowest set mask bit, and that bit is then cleared. Writes therefore come out in ascending bit order.
- R6: While the mask or the count is nonzero, every word is payload whatever its top bits hold. The mask is served before the count.
- R7: Mode code 4 (immediate) at once writes the value's low 12 bits, zero-extended, to the header's offset. It consumes no payload word.
- R8: Mode codes 5 to 15 produce no write and leave the class, offset, count and mask unchanged.
- R9: A burst header with a zero count, or a mask header with a zero mask, consumes no payload. The next word is decoded as a header.
- R10: Each write is stored in the register file of its class: class 0xF0 (decoder) or 0x5D (auxiliary). The file is indexed by the method offset in 32-bit word units. Offsets at or beyond the file depth of 16 are not stored. `rd_sel` = 0 reads the decoder file and 1 reads the auxiliary file.
- R11: While `wr_valid` is high and `wr_ready` is low, `in_ready` is low and the class, offset and data outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Command or payload word |
| wr_valid | output | 1 | Register write pending |
| wr_ready | input | 1 | Consumer takes the write |
| wr_class | output | 10 | Class ID of the write |
| wr_offset | output | 12 | Method offset of the write |
| wr_data | output | 32 | Data of the write |
| rd_sel | input | 1 | Register file select: 0 decoder, 1 auxiliary |
| rd_index | input | 4 | Register file word index |
| rd_data | output | 32 | Register file read data |

## Verification
A wrong count or mask shows up at the ports one cycle after the next word is accepted. In that cycle a payload word either appears as a write that should not exist, or it is swallowed as a header with no write. The offset sequence of the following writes then drifts from the expected one. A stale class or offset shows up on the first write after the header that should have set it. Mis-routed register file contents can be seen on the read port in the cycle after the write is accepted.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

    localparam int WORD_W  = 32;
    localparam int MODE_W  = 4;
    localparam int OFF_W   = 12;
    localparam int VAL_W   = 16;
    localparam int CLS_W   = 10;
    localparam int SCM_W   = 6;   // mask width carried by a set-class header
    localparam int IMM_W   = 12;  // immediate payload width
    localparam int MASK_W  = VAL_W;
    localparam int MIDX_W  = $clog2(MASK_W);

    typedef enum logic [MODE_W-1:0] {
        MODE_SETCLASS = 4'd0,
        MODE_INCR     = 4'd1,
        MODE_NONINCR  = 4'd2,
        MODE_MASK     = 4'd3,
        MODE_IMM      = 4'd4
    } sub_mode_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [OFF_W-1:0]  off;
        logic [VAL_W-1:0]  val;
    } hdr_t;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic [OFF_W-1:0]  off;
        logic [VAL_W-1:0]  cnt;
        logic [MASK_W-1:0] msk;
        logic              incr;
        logic              ov;
        logic [CLS_W-1:0]  ocls;
        logic [OFF_W-1:0]  ooff;
        logic [WORD_W-1:0] odata;
    } dec_state_t;

endpackage

// File: rtl/chan_cmd_lowbit.sv
module chan_cmd_lowbit #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is the last to assign.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/chan_cmd_regfile.sv
module chan_cmd_regfile #(
    parameter int               DEPTH    = 16,
    parameter int               DATA_W   = 32,
    parameter int               OFF_W    = 12,
    parameter int               CLS_W    = 10,
    parameter logic [CLS_W-1:0] CLASS_ID = 10'h0F0,
    localparam int              IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CLS_W-1:0]  wr_cls,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic              hit;
    logic [DATA_W-1:0] words [DEPTH];

    assign hit = wr_en && (wr_cls == CLASS_ID) && (wr_off < OFF_W'(DEPTH));

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit && (wr_off[IDX_W-1:0] == IDX_W'(g))) begin
                word_q <= wr_data;
            end
        end
        assign words[g] = word_q;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/chan_cmd_decoder.sv
module chan_cmd_decoder
    import chan_cmd_pkg::*;
#(
    parameter int               RF_DEPTH  = 16,
    parameter logic [CLS_W-1:0] DEC_CLASS = 10'h0F0,
    parameter logic [CLS_W-1:0] AUX_CLASS = 10'h05D,
    localparam int              RF_IDX_W  = $clog2(RF_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WORD_W-1:0]   in_word,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [CLS_W-1:0]    wr_class,
    output logic [OFF_W-1:0]    wr_offset,
    output logic [WORD_W-1:0]   wr_data,
    input  logic                rd_sel,
    input  logic [RF_IDX_W-1:0] rd_index,
    output logic [WORD_W-1:0]   rd_data
);
    localparam int NUM_FILES = 2;
    localparam logic [CLS_W-1:0] FILE_IDS [NUM_FILES] = '{DEC_CLASS, AUX_CLASS};

    dec_state_t        q, d;
    hdr_t              hdr;
    logic              accept;
    logic [MIDX_W-1:0] low_idx;
    logic              gen_wr;
    logic [OFF_W-1:0]  gen_off;
    logic [WORD_W-1:0] gen_data;
    logic [WORD_W-1:0] file_rd [NUM_FILES];

    assign hdr      = hdr_t'(in_word);
    assign in_ready = !q.ov || wr_ready;
    assign accept   = in_valid && in_ready;

    chan_cmd_lowbit #(.W(MASK_W)) u_lowbit (
        .vec (q.msk),
        .idx (low_idx)
    );

    always_comb begin
        d        = q;
        gen_wr   = 1'b0;
        gen_off  = q.off;
        gen_data = in_word;
        if (q.ov && wr_ready) d.ov = 1'b0;
        if (accept) begin
            if (q.msk != '0) begin
                gen_wr  = 1'b1;
                gen_off = q.off + OFF_W'(low_idx);
                d.msk   = q.msk & ~(MASK_W'(1) << low_idx);
            end else if (q.cnt != '0) begin
                gen_wr  = 1'b1;
                gen_off = q.off;
                d.cnt   = q.cnt - VAL_W'(1);
                if (q.incr) d.off = q.off + OFF_W'(1);
            end else begin
                case (hdr.mode)
                    MODE_SETCLASS: begin
                        d.cls = hdr.val[VAL_W-1:SCM_W];
                        d.msk = MASK_W'(hdr.val[SCM_W-1:0]);
                        d.off = hdr.off;
                    end
                    MODE_INCR, MODE_NONINCR: begin
                        d.cnt  = hdr.val;
                        d.off  = hdr.off;
                        d.incr = (hdr.mode == MODE_INCR);
                    end
                    MODE_MASK: begin
                        d.msk = hdr.val;
                        d.off = hdr.off;
                    end
                    MODE_IMM: begin
                        d.off    = hdr.off;
                        gen_wr   = 1'b1;
                        gen_off  = hdr.off;
                        gen_data = WORD_W'(hdr.val[IMM_W-1:0]);
                    end
                    default: ;
                endcase
            end
        end
        if (gen_wr) begin
            d.ov    = 1'b1;
            d.ocls  = q.cls;
            d.ooff  = gen_off;
            d.odata = gen_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
        chan_cmd_regfile #(
            .DEPTH    (RF_DEPTH),
            .DATA_W   (WORD_W),
            .OFF_W    (OFF_W),
            .CLS_W    (CLS_W),
            .CLASS_ID (FILE_IDS[f])
        ) u_rf (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (gen_wr),
            .wr_cls  (q.cls),
            .wr_off  (gen_off),
            .wr_data (gen_data),
            .rd_idx  (rd_index),
            .rd_data (file_rd[f])
        );
    end

    assign rd_data   = rd_sel ? file_rd[1] : file_rd[0];
    assign wr_valid  = q.ov;
    assign wr_class  = q.ocls;
    assign wr_offset = q.ooff;
    assign wr_data   = q.odata;
endmodule

// File: rtl/chan_cmd_decoder_chk.sv
module chan_cmd_decoder_chk
    import chan_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_word,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CLS_W-1:0]  wr_class,
    input logic [OFF_W-1:0]  wr_offset,
    input logic [WORD_W-1:0] wr_data,
    input logic [VAL_W-1:0]  cnt_q,
    input logic [MASK_W-1:0] msk_q
);
    logic take;
    logic idle;
    assign take = in_valid && in_ready;
    assign idle = (cnt_q == '0) && (msk_q == '0);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_class)
                                  && $stable(wr_offset) && $stable(wr_data));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take && (msk_q == '0) && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - VAL_W'(1));

    p_mask_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take && (msk_q != '0) |=> $countones(msk_q) == $countones($past(msk_q)) - 1);

    p_imm_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take && idle && (in_word[31:28] == 4'd4)
        |=> wr_valid && (wr_offset == $past(in_word[27:16]))
            && (wr_data == WORD_W'($past(in_word[11:0]))));

    p_unknown_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take && idle && (in_word[31:28] > 4'd4) |=> !wr_valid && (cnt_q == '0) && (msk_q == '0));

    p_payload_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take && !idle |=> wr_valid);
endmodule

bind chan_cmd_decoder chan_cmd_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_class  (wr_class),
    .wr_offset (wr_offset),
    .wr_data   (wr_data),
    .cnt_q     (q.cnt),
    .msk_q     (q.msk)
);

// File: tb/chan_cmd_decoder_bench.sv
`timescale 1ns/1ps
module chan_cmd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [9:0]  wr_class;
    logic [11:0] wr_offset;
    logic [31:0] wr_data;
    logic        rd_sel = 1'b0;
    logic [3:0]  rd_index = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_err = 0;

    logic [9:0]  cap_cls [64];
    logic [11:0] cap_off [64];
    logic [31:0] cap_dat [64];
    int          cap_n = 0;

    always #2 clk = ~clk;

    chan_cmd_decoder u_chan_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_class(wr_class), .wr_offset(wr_offset), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_index(rd_index), .rd_data(rd_data)
    );

    // Capture each write that completes at the coming rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && wr_valid && wr_ready && cap_n < 64) begin
                cap_cls[cap_n] = wr_class;
                cap_off[cap_n] = wr_offset;
                cap_dat[cap_n] = wr_data;
                cap_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic expect_wr(input int i, input logic [9:0] c, input logic [11:0] o,
                             input logic [31:0] dv, input string tag);
        chk(cap_n > i, tag, "write present", 32'(cap_n), 32'(i + 1));
        if (cap_n > i) begin
            chk(cap_cls[i] == c,  tag, "class",  32'(cap_cls[i]), 32'(c));
            chk(cap_off[i] == o,  tag, "offset", 32'(cap_off[i]), 32'(o));
            chk(cap_dat[i] == dv, tag, "data",   cap_dat[i], dv);
        end
    endtask

    task automatic expect_count(input int n, input string tag);
        chk(cap_n == n, tag, "write count", 32'(cap_n), 32'(n));
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_cap();
        cap_n = 0;
    endtask

    task automatic read_rf(input logic sel, input logic [3:0] idx, input logic [31:0] exp,
                           input string tag);
        @(negedge clk);
        rd_sel   = sel;
        rd_index = idx;
        #1;
        chk(rd_data == exp, tag, "register file word", rd_data, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", 32'(wr_valid), 32'd0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
        clear_cap();
        send(32'h4005_0011);
        settle();
        expect_count(1, "R1");
        expect_wr(0, 10'h000, 12'h005, 32'h0000_0011, "R1");
    endtask

    task automatic t_setclass();
        clear_cap();
        send(32'h0010_3C05);   // class 0xF0, mask bits 0 and 2, offset 0x010
        send(32'hCAFE_0001);
        send(32'hCAFE_0002);
        settle();
        expect_count(2, "R2");
        expect_wr(0, 10'h0F0, 12'h010, 32'hCAFE_0001, "R2");
        expect_wr(1, 10'h0F0, 12'h012, 32'hCAFE_0002, "R2");
    endtask

    task automatic t_incr();
        clear_cap();
        send(32'h1003_0003);
        send(32'h4000_0001);   // looks like an immediate header: payload (R6)
        send(32'h0012_3C05);   // looks like set-class: payload (R6)
        send(32'hF000_0003);
        settle();
        expect_count(3, "R3");
        expect_wr(0, 10'h0F0, 12'h003, 32'h4000_0001, "R3");
        expect_wr(1, 10'h0F0, 12'h004, 32'h0012_3C05, "R6");
        expect_wr(2, 10'h0F0, 12'h005, 32'hF000_0003, "R3");
    endtask

    task automatic t_nonincr();
        clear_cap();
        send(32'h2007_0002);
        send(32'h1111_1111);
        send(32'h2222_2222);
        settle();
        expect_count(2, "R4");
        expect_wr(0, 10'h0F0, 12'h007, 32'h1111_1111, "R4");
        expect_wr(1, 10'h0F0, 12'h007, 32'h2222_2222, "R4");
    endtask

    task automatic t_mask();
        clear_cap();
        send(32'h3020_8011);   // bits 0, 4, 15
        send(32'h0000_00A0);
        send(32'h0000_00A1);
        send(32'h0000_00A2);
        settle();
        expect_count(3, "R5");
        expect_wr(0, 10'h0F0, 12'h020, 32'h0000_00A0, "R5");
        expect_wr(1, 10'h0F0, 12'h024, 32'h0000_00A1, "R5");
        expect_wr(2, 10'h0F0, 12'h02F, 32'h0000_00A2, "R5");
    endtask

    task automatic t_immediate();
        clear_cap();
        send(32'h400A_FABC);
        send(32'h400B_1234);
        settle();
        expect_count(2, "R7");
        expect_wr(0, 10'h0F0, 12'h00A, 32'h0000_0ABC, "R7");
        expect_wr(1, 10'h0F0, 12'h00B, 32'h0000_0234, "R7");
    endtask

    task automatic t_unknown();
        clear_cap();
        send(32'h9003_0005);
        send(32'hF0FF_FFFF);
        send(32'h4001_0077);
        settle();
        expect_count(1, "R8");
        expect_wr(0, 10'h0F0, 12'h001, 32'h0000_0077, "R8");
    endtask

    task automatic t_zero();
        clear_cap();
        send(32'h1030_0000);
        send(32'h4002_0055);
        send(32'h3040_0000);
        send(32'h4004_0066);
        settle();
        expect_count(2, "R9");
        expect_wr(0, 10'h0F0, 12'h002, 32'h0000_0055, "R9");
        expect_wr(1, 10'h0F0, 12'h004, 32'h0000_0066, "R9");
    endtask

    task automatic t_regfile();
        read_rf(1'b0, 4'd3, 32'h4000_0001, "R10");
        read_rf(1'b0, 4'd5, 32'hF000_0003, "R10");
        read_rf(1'b0, 4'd7, 32'h2222_2222, "R10");
        read_rf(1'b0, 4'd10, 32'h0000_0ABC, "R10");
        read_rf(1'b0, 4'd4, 32'h0000_0066, "R10");
        read_rf(1'b0, 4'd0, 32'h0000_0000, "R10");   // offsets 0x10/0x20 not stored
        clear_cap();
        send(32'h0000_1740);   // class 0x5D, no mask
        send(32'h4006_0123);
        settle();
        expect_wr(0, 10'h05D, 12'h006, 32'h0000_0123, "R10");
        read_rf(1'b1, 4'd6, 32'h0000_0123, "R10");
        read_rf(1'b0, 4'd6, 32'h0000_0000, "R10");
    endtask

    task automatic t_backpressure();
        clear_cap();
        @(negedge clk);
        wr_ready = 1'b0;
        in_valid = 1'b1;
        in_word  = 32'h4008_0AAA;
        @(negedge clk);
        in_word  = 32'h4009_0BBB;
        #1;
        chk(in_ready == 1'b0, "R11", "in_ready while stalled", 32'(in_ready), 32'd0);
        chk(wr_valid == 1'b1, "R11", "wr_valid while stalled", 32'(wr_valid), 32'd1);
        @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R11", "in_ready still stalled", 32'(in_ready), 32'd0);
        chk(wr_offset == 12'h008, "R11", "held offset", 32'(wr_offset), 32'h8);
        chk(wr_data == 32'h0000_0AAA, "R11", "held data", wr_data, 32'hAAA);
        @(negedge clk);
        wr_ready = 1'b1;
        settle();
        expect_count(2, "R11");
        expect_wr(0, 10'h05D, 12'h008, 32'h0000_0AAA, "R11");
        expect_wr(1, 10'h05D, 12'h009, 32'h0000_0BBB, "R11");
    endtask

    initial begin
        #80000;
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setclass();
        t_incr();
        t_nonincr();
        t_mask();
        t_immediate();
        t_unknown();
        t_zero();
        t_regfile();
        t_backpressure();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule